// File: doc/BRIEF.md
# SPI Transmit Master with Per-Word Chip-Select Control

This block is the transmit side of an SPI master. It takes a stream of 32-bit command words. Each word holds the character to send and also the chip-select settings for that character. A DMA engine or any other word source can therefore push a flat list of words and produce framed multi-character transactions, with no processor work for each frame. A frame longer than one character is built by chaining characters. Three 8-bit characters whose hold flags are 1, 1 and 0 make one 24-bit frame under a single chip-select assertion.

The block decodes the three fields of each accepted word:
- The hold flag (bit 28) says what happens to chip select after the character.
- An 8-bit active-low pattern (bits 23:16) is driven straight onto the chip-select pins.
- The data field (bits 15:0) holds the character, and its low `CHAR_LEN` bits are sent MSB first.

SCLK idles low. MOSI changes after a falling edge and is meant to be sampled on the rising edge. The SCLK rate is the system clock divided by an even divider applied at the `clk_div` input. When a word with its hold flag cleared ends, all chip selects go high for at least one SCLK half period before the next word can assert them again.

Top module: `spi_hold_tx`

## Requirements
- R1: When bit 28 of a word is 1, the chip-select lines keep that word's pattern after its last bit until the next word is accepted, so consecutive characters form one frame.
- R2: When bit 28 of a word is 0, all chip-select lines go high after the falling SCLK edge of its last bit.
- R3: Bits 23:16 of an accepted word are driven unchanged onto `cs_n[7:0]` for the whole character (bit 16 drives `cs_n[0]`). A value of 0xFE asserts only `cs_n[0]`.
- R4: The low `CHAR_LEN` bits of the data field (bits 15:0) are shifted out MSB first. With `CHAR_LEN`=8, bits 15:8 have no effect on MOSI.
- R5: SCLK is low whenever every chip select is high. MOSI does not change while SCLK is high.
- R6: Each SCLK high phase lasts `clk_div`/2 system clock cycles. `clk_div` is even and at least 2, and it is captured when a word is accepted.
- R7: Between a word with its hold flag cleared and the next frame, all chip selects stay high for at least `clk_div`/2 system clock cycles.
- R8: `word_ready` is high only when the shifter is idle. It is low while a character shifts and during the deassert gap. It is high again on the cycle after the last falling edge of a held character.
- R9: `busy` is high from the acceptance of a word until chip select is released after a word whose hold flag is 0. It is low once that release has happened.
- R10: After reset, `cs_n` is all ones, `sclk` is low, `busy` is low and `word_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_div | input | DIV_W | Even SCLK divider, at least 2 |
| word_valid | input | 1 | Command word is offered |
| word_data | input | 32 | Command word: hold flag, chip-select pattern, data |
| word_ready | output | 1 | Block accepts a word this cycle |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out, MSB first |
| cs_n | output | 8 | Active-low chip selects |
| busy | output | 1 | A frame is open or a character is shifting |

## Verification
The bench models the slave side. It rebuilds each frame from rising SCLK edges between a chip-select fall and the following release, and compares the frame with the frame the driver queued. A design that drops chip select between held characters splits one 24-bit frame into several short frames. A design that keeps it asserted merges frames. Both show up as a frame-length mismatch.

The bench tests these further corner cases:
- It sends junk in the upper data byte. A design that shifts the wrong bits or shifts LSB first returns a different value.
- It uses a second chip-select pattern. A design that decodes the wrong field asserts the wrong line.
- It uses two divider settings. A design with a wrong divider gives a wrong high-phase width.
- It parks the block mid-frame with its hold flag set and measures the deassert gap. A design with a wrong `busy` or a missing gap is caught here.

// File: rtl/spim_pkg.sv
package spim_pkg;

    localparam int WORD_W   = 32;
    localparam int HOLD_BIT = 28;
    localparam int CS_LSB   = 16;
    localparam int CS_W     = 8;
    localparam int DATA_W   = 16;

    typedef struct packed {
        logic              hold;
        logic [CS_W-1:0]   cs_pat;
        logic [DATA_W-1:0] data;
    } cmd_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_GAP   = 2'd2
    } tx_state_t;

    function automatic cmd_t decode_word(input logic [WORD_W-1:0] w);
        cmd_t c;
        c.hold   = w[HOLD_BIT];
        c.cs_pat = w[CS_LSB +: CS_W];
        c.data   = w[DATA_W-1:0];
        return c;
    endfunction

endpackage

// File: rtl/spim_halfper.sv
module spim_halfper #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] half,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             at_end;

    assign at_end = (cnt == half - DIV_W'(1));
    assign tick   = run && at_end;

    always_ff @(posedge clk) begin
        if (rst || !run || at_end) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spim_shift.sv
module spim_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         msb
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_val;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb = sr[W-1];
endmodule

// File: rtl/spi_hold_tx.sv
module spi_hold_tx
    import spim_pkg::*;
#(
    parameter int CHAR_LEN = 8,
    parameter int DIV_W    = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  clk_div,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              sclk,
    output logic              mosi,
    output logic [CS_W-1:0]   cs_n,
    output logic              busy
);
    localparam int CNT_W = (CHAR_LEN > 1) ? $clog2(CHAR_LEN) : 1;

    tx_state_t        st;
    cmd_t             cmd;
    logic             accept;
    logic             tick;
    logic             sclk_r;
    logic             hold_r;
    logic [CS_W-1:0]  cs_r;
    logic [CNT_W-1:0] bit_cnt;
    logic [DIV_W-1:0] half_r;
    logic [DIV_W-1:0] half_in;
    logic             shift_en;

    assign cmd        = decode_word(word_data);
    assign word_ready = (st == ST_IDLE);
    assign accept     = word_valid && word_ready;
    assign half_in    = ((clk_div >> 1) == '0) ? DIV_W'(1) : (clk_div >> 1);
    assign shift_en   = (st == ST_SHIFT) && tick && sclk_r && (bit_cnt != '0);

    generate
        if (CHAR_LEN < DATA_W) begin : g_unused_hi
            logic unused_hi;
            assign unused_hi = ^cmd.data[DATA_W-1:CHAR_LEN];
        end
    endgenerate

    spim_halfper #(.DIV_W(DIV_W)) u_half (
        .clk  (clk),
        .rst  (rst),
        .run  (st != ST_IDLE),
        .half (half_r),
        .tick (tick)
    );

    spim_shift #(.W(CHAR_LEN)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (cmd.data[CHAR_LEN-1:0]),
        .shift    (shift_en),
        .msb      (mosi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            sclk_r  <= 1'b0;
            hold_r  <= 1'b0;
            cs_r    <= '1;
            bit_cnt <= '0;
            half_r  <= DIV_W'(1);
        end else begin
            case (st)
                ST_IDLE: begin
                    if (accept) begin
                        cs_r    <= cmd.cs_pat;
                        hold_r  <= cmd.hold;
                        bit_cnt <= CNT_W'(CHAR_LEN - 1);
                        half_r  <= half_in;
                        st      <= ST_SHIFT;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        if (!sclk_r) begin
                            sclk_r <= 1'b1;
                        end else begin
                            sclk_r <= 1'b0;
                            if (bit_cnt == '0) begin
                                if (hold_r) begin
                                    st <= ST_IDLE;
                                end else begin
                                    cs_r <= '1;
                                    st   <= ST_GAP;
                                end
                            end else begin
                                bit_cnt <= bit_cnt - CNT_W'(1);
                            end
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign sclk = sclk_r;
    assign cs_n = cs_r;
    assign busy = (st == ST_SHIFT) || ((st == ST_IDLE) && hold_r);
endmodule

// File: rtl/spi_hold_tx_chk.sv
module spi_hold_tx_chk (
    input logic       clk,
    input logic       rst,
    input logic       word_ready,
    input logic       sclk,
    input logic       mosi,
    input logic [7:0] cs_n,
    input logic       busy
);
    p_ready_low_shift_r8: assert property (@(posedge clk) disable iff (rst)
        sclk |-> !word_ready);

    p_mosi_stable_high_r5: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

    p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
        (&cs_n) |-> !sclk);

    p_gap_present_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(&cs_n) && !rst) |=> (&cs_n));

    p_busy_drop_released_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (&cs_n));

    p_sclk_needs_busy_r9: assert property (@(posedge clk) disable iff (rst)
        sclk |-> busy);
endmodule

bind spi_hold_tx spi_hold_tx_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .word_ready (word_ready),
    .sclk       (sclk),
    .mosi       (mosi),
    .cs_n       (cs_n),
    .busy       (busy)
);

// File: tb/tb_spi_hold_tx.sv
module tb_spi_hold_tx;
    localparam int DIV_W = 8;

    typedef struct {
        logic [7:0]  pat;
        int          nbits;
        logic [47:0] val;
    } frame_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [DIV_W-1:0] clk_div = 8'd4;
    logic             word_valid = 1'b0;
    logic [31:0]      word_data = '0;
    logic             word_ready, sclk, mosi, busy;
    logic [7:0]       cs_n;

    int checks = 0;
    int failures = 0;
    int half_exp = 2;
    bit done = 1'b0;
    frame_t exp_q[$];

    always #2 clk = ~clk;

    spi_hold_tx #(.CHAR_LEN(8), .DIV_W(DIV_W)) dut (
        .clk(clk), .rst(rst), .clk_div(clk_div),
        .word_valid(word_valid), .word_data(word_data),
        .word_ready(word_ready), .sclk(sclk), .mosi(mosi),
        .cs_n(cs_n), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_word(input logic [31:0] w);
        do @(negedge clk); while (!word_ready);
        word_data  = w;
        word_valid = 1'b1;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] pat, input int n,
                              input logic [47:0] val, input logic [7:0] junk);
        frame_t f;
        f.pat = pat; f.nbits = n * 8; f.val = val;
        exp_q.push_back(f);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            logic       h;
            b = val[8*(n-1-i) +: 8];
            h = (i < n - 1);
            send_word({3'b000, h, 4'b0000, pat, junk, b});
        end
    endtask

    // slave-side monitor and scoreboard
    bit          prev_sclk = 1'b0;
    bit          prev_mosi = 1'b0;
    bit          prev_idle = 1'b1;
    bit          in_frame = 1'b0;
    int          frames_seen = 0;
    int          gap_cnt = 0;
    int          hi_cnt = 0;
    int          bits = 0;
    logic [47:0] val = '0;
    logic [7:0]  cur_pat = '1;

    always @(negedge clk) begin
        if (!rst) begin
            automatic bit idle = &cs_n;
            if (sclk && word_ready) check(1'b0, "R8 ready while shifting", 1, 0);
            if (idle && sclk) check(1'b0, "R5 sclk high with cs idle", 1, 0);
            if (sclk && prev_sclk && mosi != prev_mosi) check(1'b0, "R5 mosi moved while sclk high", mosi, prev_mosi);
            if (!idle && !busy) check(1'b0, "R9 busy low with cs asserted", 0, 1);
            if (prev_idle && !idle) begin
                if (frames_seen > 0) check(gap_cnt >= half_exp, "R7 deassert gap", gap_cnt, half_exp);
                in_frame = 1'b1; cur_pat = cs_n; bits = 0; val = '0; gap_cnt = 0;
            end
            if (!idle && in_frame && cs_n != cur_pat) check(1'b0, "R3 pattern changed mid frame", cs_n, cur_pat);
            if (sclk && !prev_sclk) begin
                val = {val[46:0], mosi};
                bits++;
            end
            if (sclk) hi_cnt++;
            else if (prev_sclk) begin
                check(hi_cnt == half_exp, "R6 sclk high width", hi_cnt, half_exp);
                hi_cnt = 0;
            end
            if (!prev_idle && idle && in_frame) begin
                in_frame = 1'b0;
                frames_seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2 unexpected frame", bits, 0);
                end else begin
                    automatic frame_t f = exp_q.pop_front();
                    check(cur_pat == f.pat, "R3 chip-select pattern", cur_pat, f.pat);
                    check(bits == f.nbits, "R1 R2 frame length", bits, f.nbits);
                    check(val == f.val, "R4 frame data MSB first", val, f.val);
                end
            end
            if (idle) gap_cnt++;
            prev_idle = idle;
            prev_sclk = sclk;
            prev_mosi = mosi;
        end
    end

    task automatic drain();
        int guard = 0;
        while ((exp_q.size() != 0 || !(&cs_n) || !word_ready) && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    initial begin
        #200000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(cs_n == 8'hFF, "R10 cs_n reset", cs_n, 8'hFF);
        check(sclk == 1'b0, "R10 sclk reset", sclk, 0);
        check(busy == 1'b0, "R10 busy reset", busy, 0);
        check(word_ready == 1'b1, "R10 ready reset", word_ready, 1);

        // R1 R4: 24-bit frames from three held 8-bit characters on chip select 0
        send_frame(8'hFE, 3, 48'h100000, 8'h00);
        send_frame(8'hFE, 3, 48'h11A53C, 8'h00);
        // R2 R3: single-character frame on chip select 1
        send_frame(8'hFD, 1, 48'h81, 8'h00);
        // R4: junk in the upper data byte must not reach MOSI
        send_frame(8'hFE, 1, 48'h5A, 8'hFF);
        drain();

        // R1 R9: park mid-frame with hold set
        begin
            frame_t f;
            f.pat = 8'hFB; f.nbits = 16; f.val = 48'hA5C3;
            exp_q.push_back(f);
            send_word(32'h10FB_00A5);
            repeat (40) @(negedge clk);
            check(cs_n == 8'hFB, "R1 cs held between characters", cs_n, 8'hFB);
            check(busy == 1'b1, "R9 busy while frame open", busy, 1);
            check(word_ready == 1'b1, "R8 ready after held character", word_ready, 1);
            send_word(32'h00FB_FFC3);
        end
        drain();
        check(busy == 1'b0, "R9 busy low after release", busy, 0);
        check(cs_n == 8'hFF, "R2 cs released after frame", cs_n, 8'hFF);

        // R6: another divider setting
        clk_div = 8'd6;
        half_exp = 3;
        send_frame(8'hFE, 2, 48'hF00F, 8'h3C);
        send_frame(8'h7F, 3, 48'h172345, 8'h00);
        drain();

        // R6: minimum divider
        clk_div = 8'd2;
        half_exp = 1;
        send_frame(8'hFE, 3, 48'hFFFFFF, 8'h00);
        send_frame(8'hFE, 1, 48'h01, 8'h00);
        drain();

        check(exp_q.size() == 0, "R1 all frames observed", exp_q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule